// File: doc/BRIEF.md
# Horizontal Sync Noise Qualifier

This block judges, once per field, whether the incoming horizontal sync pulses are clean enough to trust. The vertical divider opens a gating window that spans fifteen lines. Each sync pulse inside that window arrives as a one-cycle strobe with two digital noise flags from an analog comparator. The first flag marks a pulse whose noise is worse than the nominal 19 dB signal-to-noise threshold. The second, stricter flag marks a pulse that sits clear of the threshold by the hysteresis margin of about 3 dB. The block counts the pulses that qualify. When the field strobe arrives at the end of the window, it latches a clean or noisy status.

The status sets the operating mode of the horizontal phase detector. A clean input gives ungated operation with the normal time constant. A noisy input gives gated sync detection with the slow time constant. The status also selects the vertical sync integration time. The short integration time (about 12 µs) is used only when the input is noisy and a transmitter is identified. In every other case the long time (about 19 µs) applies.

Top module: `sync_quality_qual`

## Requirements
- R1: After reset `sync_clean` is 0, and both `pd_gated` and `pd_slow` are 1.
- R2: The qualifying-pulse count clears when `gate_win` rises, so pulses from an earlier window that ended without a field strobe do not carry into the next decision.
- R3: A `pulse_stb` that arrives while `gate_win` is 0 has no effect on the decision.
- R4: Within one window only the first `WIN_PULSES` (15) strobes are evaluated, and any later strobes in the same window are ignored.
- R5: On a `field_stb` cycle, `sync_clean` is loaded with 1 when at least `PASS_MIN` (12) evaluated pulses qualified, and with 0 otherwise. The count used is the one held before that cycle.
- R6: `sync_clean` changes only in the cycle after a `field_stb`.
- R7: While `sync_clean` is 1, a pulse qualifies when `pulse_noisy` is 0, and `pulse_clean` is ignored.
- R8: While `sync_clean` is 0, a pulse qualifies only when `pulse_clean` is 1, and `pulse_noisy` is ignored.
- R9: When `sync_clean` is 1, `pd_gated` and `pd_slow` are 0 (ungated, normal time constant). When `sync_clean` is 0, both are 1 (gated, slow time constant).
- R10: `vint_short` is 1 only when `sync_clean` is 0 and `tx_found` is 1. When `tx_found` is 0 it is 0 whatever the noise status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pulse_stb | input | 1 | One-cycle strobe per measured sync pulse |
| pulse_noisy | input | 1 | Pulse noise is worse than the entry threshold |
| pulse_clean | input | 1 | Pulse noise is better than the stricter exit threshold |
| gate_win | input | 1 | Gating window from the vertical divider |
| field_stb | input | 1 | Latch the decision (end of window) |
| tx_found | input | 1 | Transmitter identified |
| sync_clean | output | 1 | 1 = sync judged clean |
| pd_gated | output | 1 | Phase detector uses gated sync detection |
| pd_slow | output | 1 | Phase detector uses the slow time constant |
| vint_short | output | 1 | Vertical sync integration uses the short time |

## Verification
Windows that hold exactly 11 and exactly 12 qualifying pulses fall on either side of the vote threshold. Pulses in the band between the two thresholds (noisy flag 0, clean flag 0) should count in the clean state and not in the noisy state, so these windows show that the hysteresis flags are swapped correctly. Qualifying pulses placed after the window closes, past the fifteenth strobe, or in an earlier window with no strobe show that each of those is ignored. Changing `tx_found` in both states shows that the integration-time select depends on transmitter presence.

// File: rtl/sync_quality_qual.sv
module sync_quality_qual #(
  parameter int WIN_PULSES = 15,
  parameter int PASS_MIN   = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_stb,
  input  logic pulse_noisy,
  input  logic pulse_clean,
  input  logic gate_win,
  input  logic field_stb,
  input  logic tx_found,
  output logic sync_clean,
  output logic pd_gated,
  output logic pd_slow,
  output logic vint_short
);
  localparam int CNT_W = $clog2(WIN_PULSES + 1);

  logic             gate_q;
  logic [CNT_W-1:0] seen_cnt;
  logic [CNT_W-1:0] good_cnt;
  logic             win_start;
  logic             take;
  logic             pulse_ok;

  assign win_start = gate_win & ~gate_q;
  assign take      = pulse_stb & gate_win & (win_start | (seen_cnt < CNT_W'(WIN_PULSES)));
  assign pulse_ok  = sync_clean ? ~pulse_noisy : pulse_clean;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gate_q   <= 1'b0;
      seen_cnt <= '0;
      good_cnt <= '0;
    end else begin
      gate_q <= gate_win;
      if (win_start) begin
        seen_cnt <= CNT_W'(take);
        good_cnt <= CNT_W'(take & pulse_ok);
      end else if (take) begin
        seen_cnt <= seen_cnt + 1'b1;
        good_cnt <= good_cnt + CNT_W'(pulse_ok);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      sync_clean <= 1'b0;
    else if (field_stb)
      sync_clean <= (good_cnt >= CNT_W'(PASS_MIN));
  end

  assign pd_gated   = ~sync_clean;
  assign pd_slow    = ~sync_clean;
  assign vint_short = ~sync_clean & tx_found;
endmodule

// File: rtl/sync_quality_qual_chk.sv
module sync_quality_qual_chk #(
  parameter int WIN_PULSES = 15,
  parameter int PASS_MIN   = 12,
  parameter int CNT_W      = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             gate_win,
  input logic             field_stb,
  input logic             tx_found,
  input logic             sync_clean,
  input logic             vint_short,
  input logic [CNT_W-1:0] good_cnt,
  input logic [CNT_W-1:0] seen_cnt
);
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !field_stb |=> $stable(sync_clean));

  assert_enter_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_clean) |-> $past(good_cnt) >= CNT_W'(PASS_MIN));

  assert_leave_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sync_clean) |-> $past(good_cnt) < CNT_W'(PASS_MIN));

  assert_outside_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_win |=> $stable(good_cnt));

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_cnt <= CNT_W'(WIN_PULSES)) && (good_cnt <= seen_cnt));

  assert_win_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_win) |=> good_cnt <= CNT_W'(1));

  assert_long_integ_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_found |-> !vint_short);
endmodule

bind sync_quality_qual sync_quality_qual_chk #(
  .WIN_PULSES(WIN_PULSES), .PASS_MIN(PASS_MIN), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .gate_win(gate_win), .field_stb(field_stb),
  .tx_found(tx_found), .sync_clean(sync_clean), .vint_short(vint_short),
  .good_cnt(good_cnt), .seen_cnt(seen_cnt)
);

// File: tb/sync_quality_qual_bench.sv
module sync_quality_qual_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pulse_stb = 1'b0, pulse_noisy = 1'b0, pulse_clean = 1'b0;
  logic gate_win = 1'b0, field_stb = 1'b0, tx_found = 1'b1;
  logic sync_clean, pd_gated, pd_slow, vint_short;
  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  sync_quality_qual u_sync_quality_qual (
    .clk(clk), .rst_n(rst_n), .pulse_stb(pulse_stb), .pulse_noisy(pulse_noisy),
    .pulse_clean(pulse_clean), .gate_win(gate_win), .field_stb(field_stb),
    .tx_found(tx_found), .sync_clean(sync_clean), .pd_gated(pd_gated),
    .pd_slow(pd_slow), .vint_short(vint_short)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic pulses(input int n, input logic nz, input logic cl);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); pulse_stb = 1'b1; pulse_noisy = nz; pulse_clean = cl;
      @(negedge clk); pulse_stb = 1'b0;
    end
  endtask

  task automatic open_win();
    @(negedge clk); gate_win = 1'b1;
  endtask

  task automatic close_win();
    @(negedge clk); gate_win = 1'b0;
  endtask

  task automatic strobe();
    @(negedge clk); field_stb = 1'b1;
    @(negedge clk); field_stb = 1'b0;
  endtask

  task automatic go_clean();
    open_win(); pulses(15, 1'b0, 1'b1); close_win(); strobe();
  endtask

  task automatic go_noisy();
    open_win(); pulses(15, 1'b1, 1'b0); close_win(); strobe();
  endtask

  task automatic t_reset();
    chk("R1 sync_clean after reset", sync_clean, 1'b0);
    chk("R1 pd_gated after reset", pd_gated, 1'b1);
    chk("R1 pd_slow after reset", pd_slow, 1'b1);
  endtask

  task automatic t_threshold();
    open_win(); pulses(11, 1'b0, 1'b1); pulses(4, 1'b1, 1'b0); close_win(); strobe();
    chk("R5 11 of 15 stays noisy", sync_clean, 1'b0);
    open_win(); pulses(12, 1'b0, 1'b1); pulses(3, 1'b1, 1'b0); close_win(); strobe();
    chk("R5 12 of 15 becomes clean", sync_clean, 1'b1);
    chk("R9 clean gives ungated", pd_gated, 1'b0);
    chk("R9 clean gives normal tc", pd_slow, 1'b0);
  endtask

  task automatic t_hold();
    go_clean();
    open_win(); pulses(15, 1'b1, 1'b0); close_win();
    repeat (3) @(negedge clk);
    chk("R6 no change before strobe", sync_clean, 1'b1);
    strobe();
    chk("R5 all noisy leaves clean", sync_clean, 1'b0);
    chk("R9 noisy gives gated", pd_gated, 1'b1);
    chk("R9 noisy gives slow tc", pd_slow, 1'b1);
  endtask

  task automatic t_hysteresis();
    go_noisy();
    open_win(); pulses(15, 1'b0, 1'b0); close_win(); strobe();
    chk("R8 mid band ignored while noisy", sync_clean, 1'b0);
    go_clean();
    open_win(); pulses(15, 1'b0, 1'b0); close_win(); strobe();
    chk("R7 mid band counts while clean", sync_clean, 1'b1);
    open_win(); pulses(12, 1'b0, 1'b0); pulses(3, 1'b1, 1'b1); close_win(); strobe();
    chk("R7 clean flag ignored while clean", sync_clean, 1'b1);
  endtask

  task automatic t_outside();
    go_noisy();
    open_win(); pulses(11, 1'b0, 1'b1); close_win();
    pulses(5, 1'b0, 1'b1);
    strobe();
    chk("R3 pulses outside window ignored", sync_clean, 1'b0);
  endtask

  task automatic t_clear();
    go_noisy();
    open_win(); pulses(12, 1'b0, 1'b1); close_win();
    open_win(); pulses(6, 1'b0, 1'b1); close_win(); strobe();
    chk("R2 count cleared at window start", sync_clean, 1'b0);
  endtask

  task automatic t_cap();
    go_noisy();
    open_win(); pulses(4, 1'b0, 1'b0); pulses(15, 1'b0, 1'b1); close_win(); strobe();
    chk("R4 strobes past 15 ignored", sync_clean, 1'b0);
    open_win(); pulses(12, 1'b0, 1'b1); pulses(8, 1'b0, 1'b0); close_win(); strobe();
    chk("R4 first 15 pass", sync_clean, 1'b1);
  endtask

  task automatic t_integ();
    go_noisy();
    tx_found = 1'b1; @(negedge clk);
    chk("R10 noisy with tx is short", vint_short, 1'b1);
    tx_found = 1'b0; @(negedge clk);
    chk("R10 noisy without tx is long", vint_short, 1'b0);
    tx_found = 1'b1;
    go_clean();
    chk("R10 clean with tx is long", vint_short, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_threshold();
    t_hold();
    t_hysteresis();
    t_outside();
    t_clear();
    t_cap();
    t_integ();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule